// File: doc/BRIEF.md
# Strap-Configured I2C Register Target

This block is the two-wire serial target for a 64-entry, 24-bit register map. It borrows the pins of the chip's four-wire serial port. The serial clock pin serves as SCL. The serial data-out pin serves as an open-drain SDA. The chip-select pin is read once, right after reset, and a high level there turns the two-wire mode on. The data-in pin is also read once at that moment, and its level picks one of two 7-bit device addresses. After that first sample, neither strap pin has any effect.

A host writes a register by sending the device address with the write bit, then a pointer byte, then three data bytes with the most significant byte first. The target raises a one-cycle write strobe toward the register map only once the third data byte has arrived. To read, the host sends the device address and the pointer byte. It then issues a repeated start with the read bit, clocks out three bytes, and NACKs the last one. Both lines are oversampled with the system clock and filtered before any protocol decision is made. The target only ever pulls SDA low or lets it go. It never stretches the clock.

Top module: `i2c_reg_target`

## Requirements
- R1: The mode output `i2c_mode_o` takes the level of `strap_cs_i` at the first internal clock after reset release, and keeps that value until the next reset whatever `strap_cs_i` does later.
- R2: While the mode is off, the block never pulls SDA and never issues a register write, whatever happens on SCL and SDA.
- R3: The device address is 0x08 when `strap_mosi_i` was low at the strap sample and 0x0A when it was high. A matching address byte is ACKed by pulling SDA low during the ninth clock.
- R4: An address byte that does not match, including the general call address 0x00, is NACKed (SDA released), and the rest of that transfer causes no write.
- R5: A write transfer is address byte (R/W bit 0), then pointer byte, then three data bytes sent MSB first. Every one of these bytes is ACKed. The upper two bits of the pointer byte are ignored. After the third data byte, `reg_wr_o` pulses for exactly one cycle, with `reg_addr_o` holding the pointer and `reg_wdata_o` holding the 24 assembled bits.
- R6: A write transfer that stops after fewer than three data bytes issues no register write, and the addressed register keeps its value.
- R7: Any data byte after the third in the same write transfer is NACKed and issues no further write.
- R8: After a repeated start with the read address (R/W bit 1), the block returns the register selected by the pointer as three bytes, MSB first. The pointer is kept across the repeated start, and SDA is released after the host NACKs the third byte.
- R9: The block changes its SDA pull only while SCL is low, and SDA is released whenever the bus is idle after a stop.
- R10: A pulse on SCL or SDA that lasts one system clock sample is ignored, so a transfer with such glitches inside its data bits completes exactly as one without them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset (cold start) |
| strap_cs_i | input | 1 | Chip-select pin level; high at cold start selects two-wire mode |
| strap_mosi_i | input | 1 | Data-in pin level; picks one of two device addresses at cold start |
| scl_i | input | 1 | Bus clock taken from the serial clock pin |
| sda_i | input | 1 | Bus data level seen on the shared data-out pin |
| sda_pull_o | output | 1 | 1 pulls the SDA pad low; 0 releases it |
| i2c_mode_o | output | 1 | Latched two-wire mode select |
| reg_addr_o | output | 6 | Register pointer toward the register map |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_wdata_o | output | 24 | Assembled 24-bit write data |
| reg_rdata_i | input | 24 | Read data of the register at `reg_addr_o` |

## Verification
The hardest case to reach from the ports is a glitch that would be fatal if it got through. One example is a single-sample low pulse on SCL while SCL is high, which would add a bit. Another is a single-sample dip on SDA during a high data bit, which would look like a start. The bench places one of each inside every bit of a full write transfer, timed on the falling edge of the system clock so that exactly one sample catches it. It then reads the register back. The repeated-start read is the other hard path, since the pointer has to survive a second start condition in the middle of a transfer. The bench reaches it by first writing a known value and then following a pointer-only write with a read address.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_SKIP
  } i2cs_state_e;

endpackage

// File: rtl/i2cs_deglitch.sv
// Two-flop synchronizer followed by a run-length filter: the clean output
// only follows the input after FILT consecutive equal samples.
module i2cs_deglitch #(
  parameter int FILT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic clean_o
);

  localparam int CW = $clog2(FILT + 1);

  logic [1:0]    sync_q;
  logic          clean_q, clean_n;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    clean_n = clean_q;
    cnt_n   = cnt_q;
    if (sync_q[1] == clean_q) begin
      cnt_n = '0;
    end else if (cnt_q == CW'(FILT - 1)) begin
      clean_n = sync_q[1];
      cnt_n   = '0;
    end else begin
      cnt_n = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 2'b11;
      clean_q <= 1'b1;
      cnt_q   <= '0;
    end else begin
      sync_q  <= {sync_q[0], raw_i};
      clean_q <= clean_n;
      cnt_q   <= cnt_n;
    end
  end

  assign clean_o = clean_q;

endmodule

// File: rtl/i2cs_strap.sv
// Samples the two strap pins exactly once after reset release.
module i2cs_strap (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_pin_i,
  input  logic mosi_pin_i,
  output logic mode_o,
  output logic sel_o
);

  logic done_q, done_n;
  logic mode_q, mode_n;
  logic sel_q, sel_n;

  always_comb begin
    done_n = done_q;
    mode_n = mode_q;
    sel_n  = sel_q;
    if (!done_q) begin
      done_n = 1'b1;
      mode_n = cs_pin_i;
      sel_n  = mosi_pin_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      mode_q <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      done_q <= done_n;
      mode_q <= mode_n;
      sel_q  <= sel_n;
    end
  end

  assign mode_o = mode_q;
  assign sel_o  = sel_q;

endmodule

// File: rtl/i2cs_fsm.sv
// Bus protocol engine: start/stop detection, address match, ACK,
// pointer byte, three-byte write assembly and three-byte read shifting.
module i2cs_fsm
  import i2cs_pkg::*;
#(
  parameter int         AW      = 6,
  parameter int         DW      = 24,
  parameter logic [6:0] ADDR_LO = 7'h08,
  parameter logic [6:0] ADDR_HI = 7'h0A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          sel_i,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [DW-1:0] rdata_i,
  output logic          sda_pull_o,
  output logic [AW-1:0] ptr_o,
  output logic          wr_o,
  output logic [DW-1:0] wdata_o
);

  localparam int NB  = DW / 8;
  localparam int BCW = $clog2(NB + 2);
  localparam int ACW = DW - 8;

  i2cs_state_e    state_q, state_n;
  logic           scl_d, sda_d;
  logic [3:0]     bit_q, bit_n;
  logic [BCW-1:0] byte_q, byte_n;
  logic [7:0]     shift_q, shift_n;
  logic [AW-1:0]  ptr_q, ptr_n;
  logic [ACW-1:0] acc_q, acc_n;
  logic [DW-1:0]  tx_q, tx_n;
  logic [DW-1:0]  wdata_q, wdata_n;
  logic           pull_q, pull_n;
  logic           wr_q, wr_n;
  logic           rw_q, rw_n;

  logic       scl_rise, scl_fall, bus_start, bus_stop;
  logic [6:0] my_addr;

  assign scl_rise  = scl_i & ~scl_d;
  assign scl_fall  = ~scl_i & scl_d;
  assign bus_start = scl_i & scl_d & sda_d & ~sda_i;
  assign bus_stop  = scl_i & scl_d & ~sda_d & sda_i;
  assign my_addr   = sel_i ? ADDR_HI : ADDR_LO;

  always_comb begin
    state_n = state_q;
    bit_n   = bit_q;
    byte_n  = byte_q;
    shift_n = shift_q;
    ptr_n   = ptr_q;
    acc_n   = acc_q;
    tx_n    = tx_q;
    wdata_n = wdata_q;
    pull_n  = pull_q;
    rw_n    = rw_q;
    wr_n    = 1'b0;

    if (!en_i) begin
      state_n = ST_IDLE;
      pull_n  = 1'b0;
    end else if (bus_start) begin
      state_n = ST_ADDR;
      bit_n   = 4'd0;
      pull_n  = 1'b0;
    end else if (bus_stop) begin
      state_n = ST_IDLE;
      pull_n  = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise) begin
            shift_n = {shift_q[6:0], sda_i};
            bit_n   = bit_q + 4'd1;
          end else if (scl_fall && bit_q == 4'd8) begin
            if (shift_q[7:1] == my_addr && shift_q[7:1] != 7'd0) begin
              pull_n  = 1'b1;
              rw_n    = shift_q[0];
              state_n = ST_ADDR_ACK;
            end else begin
              state_n = ST_SKIP;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            bit_n  = 4'd0;
            byte_n = '0;
            if (rw_q) begin
              tx_n    = rdata_i;
              pull_n  = ~rdata_i[DW-1];
              state_n = ST_TX;
            end else begin
              pull_n  = 1'b0;
              state_n = ST_RX;
            end
          end
        end
        ST_RX: begin
          if (scl_rise) begin
            shift_n = {shift_q[6:0], sda_i};
            bit_n   = bit_q + 4'd1;
          end else if (scl_fall && bit_q == 4'd8) begin
            if (byte_q <= BCW'(NB)) begin
              pull_n  = 1'b1;
              state_n = ST_RX_ACK;
              byte_n  = byte_q + BCW'(1);
              if (byte_q == '0) begin
                ptr_n = shift_q[AW-1:0];
              end else if (byte_q == BCW'(NB)) begin
                wr_n    = 1'b1;
                wdata_n = {acc_q, shift_q};
              end else begin
                acc_n = {acc_q[ACW-9:0], shift_q};
              end
            end else begin
              state_n = ST_SKIP;
            end
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            pull_n  = 1'b0;
            bit_n   = 4'd0;
            state_n = ST_RX;
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bit_n = bit_q + 4'd1;
          end else if (scl_fall) begin
            if (bit_q == 4'd8) begin
              pull_n  = 1'b0;
              state_n = ST_TX_ACK;
            end else begin
              pull_n = ~tx_q[DW-2];
              tx_n   = {tx_q[DW-2:0], 1'b0};
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            if (sda_i) state_n = ST_SKIP;
            else       byte_n  = byte_q + BCW'(1);
          end else if (scl_fall) begin
            bit_n = 4'd0;
            if (byte_q == BCW'(NB)) begin
              state_n = ST_SKIP;
            end else begin
              pull_n  = ~tx_q[DW-2];
              tx_n    = {tx_q[DW-2:0], 1'b0};
              state_n = ST_TX;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      scl_d   <= 1'b1;
      sda_d   <= 1'b1;
      bit_q   <= '0;
      byte_q  <= '0;
      shift_q <= '0;
      ptr_q   <= '0;
      acc_q   <= '0;
      tx_q    <= '0;
      wdata_q <= '0;
      pull_q  <= 1'b0;
      wr_q    <= 1'b0;
      rw_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      scl_d   <= scl_i;
      sda_d   <= sda_i;
      bit_q   <= bit_n;
      byte_q  <= byte_n;
      shift_q <= shift_n;
      ptr_q   <= ptr_n;
      acc_q   <= acc_n;
      tx_q    <= tx_n;
      wdata_q <= wdata_n;
      pull_q  <= pull_n;
      wr_q    <= wr_n;
      rw_q    <= rw_n;
    end
  end

  assign sda_pull_o = pull_q;
  assign ptr_o      = ptr_q;
  assign wr_o       = wr_q;
  assign wdata_o    = wdata_q;

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
  parameter int         AW      = 6,
  parameter int         DW      = 24,
  parameter int         FILT    = 2,
  parameter logic [6:0] ADDR_LO = 7'h08,
  parameter logic [6:0] ADDR_HI = 7'h0A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap_cs_i,
  input  logic          strap_mosi_i,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_pull_o,
  output logic          i2c_mode_o,
  output logic [AW-1:0] reg_addr_o,
  output logic          reg_wr_o,
  output logic [DW-1:0] reg_wdata_o,
  input  logic [DW-1:0] reg_rdata_i
);

  localparam int NLINE = 2;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [NLINE-1:0] raw_w, clean_w;
  logic             mode_w, sel_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign raw_w = {sda_i, scl_i};

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    i2cs_deglitch #(.FILT(FILT)) u_flt (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .raw_i   (raw_w[g]),
      .clean_o (clean_w[g])
    );
  end

  i2cs_strap u_strap (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cs_pin_i   (strap_cs_i),
    .mosi_pin_i (strap_mosi_i),
    .mode_o     (mode_w),
    .sel_o      (sel_w)
  );

  i2cs_fsm #(
    .AW(AW), .DW(DW), .ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .en_i       (mode_w),
    .sel_i      (sel_w),
    .scl_i      (clean_w[0]),
    .sda_i      (clean_w[1]),
    .rdata_i    (reg_rdata_i),
    .sda_pull_o (sda_pull_o),
    .ptr_o      (reg_addr_o),
    .wr_o       (reg_wr_o),
    .wdata_o    (reg_wdata_o)
  );

  assign i2c_mode_o = mode_w;

endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic i2c_mode_o,
  input logic sda_pull_o,
  input logic reg_wr_o
);

  logic [2:0] age_q;
  logic       armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= 3'd0;
    else if (age_q != 3'd7)  age_q <= age_q + 3'd1;
  end
  assign armed = (age_q >= 3'd6);

  // R1: strap result is frozen after the cold-start sample
  assert_mode_locked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> $stable(i2c_mode_o));

  // R2: no bus activity leaves the block while the mode is off
  assert_quiet_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !i2c_mode_o) |-> (!sda_pull_o && !reg_wr_o));

  // R5: the write strobe is a single cycle
  assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |=> !reg_wr_o);

  // R5: a write only commits while the bus clock is low (after the 8th bit)
  assert_strobe_scl_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |-> !scl_i);

  // R9: the SDA pull only moves while SCL is low
  assert_sda_moves_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$stable(sda_pull_o)) |-> !scl_i);

endmodule

bind i2c_reg_target i2cs_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_i      (scl_i),
  .i2c_mode_o (i2c_mode_o),
  .sda_pull_o (sda_pull_o),
  .reg_wr_o   (reg_wr_o)
);

// File: tb/i2c_reg_target_tb_top.sv
module i2c_reg_target_tb_top;

  localparam int Q = 16;

  logic        clk;
  logic        rst_n, strap_cs, strap_mosi;
  logic        m_scl, m_sda_low, g_scl, g_sda;
  logic        scl_w, sda_w;
  logic        sda_pull, i2c_mode, reg_wr;
  logic [5:0]  reg_addr;
  logic [23:0] reg_wdata, reg_rdata;
  logic [23:0] rmap [64];

  int total = 0;
  int bad   = 0;
  int wr_seen = 0;

  typedef struct packed { logic [5:0] a; logic [23:0] d; } wr_t;
  wr_t expq[$];

  initial clk = 1'b0;
  always #4 clk = ~clk;

  assign scl_w     = m_scl & ~g_scl;
  assign sda_w     = ~(m_sda_low | sda_pull | g_sda);
  assign reg_rdata = rmap[reg_addr];

  i2c_reg_target dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .strap_cs_i   (strap_cs),
    .strap_mosi_i (strap_mosi),
    .scl_i        (scl_w),
    .sda_i        (sda_w),
    .sda_pull_o   (sda_pull),
    .i2c_mode_o   (i2c_mode),
    .reg_addr_o   (reg_addr),
    .reg_wr_o     (reg_wr),
    .reg_wdata_o  (reg_wdata),
    .reg_rdata_i  (reg_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  // Register-map model and scoreboard monitor
  initial begin
    for (int i = 0; i < 64; i++) rmap[i] = 24'h5A5A5A ^ (24'h010101 * i);
    forever begin
      @(negedge clk);
      if (rst_n && reg_wr) begin
        wr_seen++;
        rmap[reg_addr] = reg_wdata;
        if (expq.size() == 0) begin
          chk(1'b0, "R5 unexpected write", {2'b0, reg_addr, reg_wdata}, 32'h0);
        end else begin
          wr_t e;
          e = expq.pop_front();
          chk(reg_addr == e.a && reg_wdata == e.d, "R5 write content",
              {2'b0, reg_addr, reg_wdata}, {2'b0, e.a, e.d});
        end
      end
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    summary();
    $finish;
  end

  task automatic hold();
    repeat (Q) @(negedge clk);
  endtask

  task automatic do_reset(input logic cs, input logic mosi);
    @(negedge clk);
    rst_n = 1'b0; strap_cs = cs; strap_mosi = mosi;
    m_scl = 1'b1; m_sda_low = 1'b0; g_scl = 1'b0; g_sda = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda_low = 1'b0; m_scl = 1'b1; hold();
    m_sda_low = 1'b1; hold();
    m_scl = 1'b0; hold();
  endtask

  task automatic i2c_rstart();
    m_sda_low = 1'b0; hold();
    m_scl = 1'b1; hold();
    m_sda_low = 1'b1; hold();
    m_scl = 1'b0; hold();
  endtask

  task automatic i2c_stop();
    m_sda_low = 1'b1; hold();
    m_scl = 1'b1; hold();
    m_sda_low = 1'b0; hold();
  endtask

  task automatic send_bit(input logic b, input bit gl);
    m_sda_low = ~b; hold();
    m_scl = 1'b1;
    repeat (Q/2) @(negedge clk);
    if (gl) begin
      g_scl = 1'b1; @(negedge clk); g_scl = 1'b0;
      @(negedge clk);
      if (b) begin g_sda = 1'b1; @(negedge clk); g_sda = 1'b0; end
    end
    hold();
    m_scl = 1'b0; hold();
  endtask

  task automatic wr_byte(input logic [7:0] b, input bit gl, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i], gl);
    m_sda_low = 1'b0; hold();
    m_scl = 1'b1; hold();
    ack = ~sda_w;
    hold();
    m_scl = 1'b0; hold();
  endtask

  task automatic rd_byte(input logic host_ack, output logic [7:0] b);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      m_sda_low = 1'b0; hold();
      m_scl = 1'b1; hold();
      b = {b[6:0], sda_w};
      hold();
      m_scl = 1'b0; hold();
    end
    send_bit(~host_ack, 1'b0);
    m_sda_low = 1'b0;
  endtask

  task automatic do_write(input logic [6:0] dev, input logic [7:0] ptr, input logic [23:0] d,
                          input int nd, input bit gl, output logic [5:0] acks);
    logic a;
    acks = '0;
    i2c_start();
    wr_byte({dev, 1'b0}, gl, a); acks[0] = a;
    wr_byte(ptr, gl, a);         acks[1] = a;
    for (int k = 0; k < nd; k++) begin
      wr_byte((k < 3) ? d[23-8*k -: 8] : 8'h77, gl, a);
      acks[2+k] = a;
    end
    i2c_stop();
    hold();
  endtask

  task automatic do_read(input logic [6:0] dev, input logic [7:0] ptr,
                         output logic [23:0] d, output logic [2:0] acks);
    logic a;
    logic [7:0] b;
    i2c_start();
    wr_byte({dev, 1'b0}, 1'b0, a); acks[0] = a;
    wr_byte(ptr, 1'b0, a);         acks[1] = a;
    i2c_rstart();
    wr_byte({dev, 1'b1}, 1'b0, a); acks[2] = a;
    rd_byte(1'b1, b); d[23:16] = b;
    rd_byte(1'b1, b); d[15:8]  = b;
    rd_byte(1'b0, b); d[7:0]   = b;
    i2c_stop();
    hold();
  endtask

  initial begin
    logic [5:0]  acks;
    logic [2:0]  racks;
    logic [23:0] rd;
    int          seen0;

    rst_n = 1'b0; strap_cs = 1'b0; strap_mosi = 1'b0;
    m_scl = 1'b1; m_sda_low = 1'b0; g_scl = 1'b0; g_sda = 1'b0;

    // Mode off: chip-select strap low
    do_reset(1'b0, 1'b0);
    chk(i2c_mode == 1'b0, "R1 reset mode off", {31'b0, i2c_mode}, 32'h0);
    chk(sda_pull == 1'b0 && reg_wr == 1'b0, "R9 reset idle outputs", {30'b0, sda_pull, reg_wr}, 32'h0);
    do_write(7'h08, 8'h05, 24'h123456, 3, 1'b0, acks);
    chk(acks == 6'b0, "R2 no ack while off", {26'b0, acks}, 32'h0);
    chk(wr_seen == 0, "R2 no write while off", wr_seen, 32'h0);

    // Mode on, address strap low
    do_reset(1'b1, 1'b0);
    chk(i2c_mode == 1'b1, "R1 strap high selects mode", {31'b0, i2c_mode}, 32'h1);
    strap_cs = 1'b0; strap_mosi = 1'b1;
    repeat (20) @(negedge clk);
    chk(i2c_mode == 1'b1, "R1 later strap change ignored", {31'b0, i2c_mode}, 32'h1);

    expq.push_back('{a: 6'd5, d: 24'hA1B2C3});
    do_write(7'h08, 8'h05, 24'hA1B2C3, 3, 1'b0, acks);
    chk(acks == 6'b011111, "R3 R5 full write acks", {26'b0, acks}, 32'h1F);
    chk(wr_seen == 1, "R5 one write issued", wr_seen, 32'h1);
    chk(sda_pull == 1'b0, "R9 released after stop", {31'b0, sda_pull}, 32'h0);

    expq.push_back('{a: 6'd7, d: 24'h00FF10});
    do_write(7'h08, 8'hC7, 24'h00FF10, 3, 1'b0, acks);
    chk(acks == 6'b011111, "R5 pointer high bits ignored acks", {26'b0, acks}, 32'h1F);

    seen0 = wr_seen;
    do_write(7'h0A, 8'h05, 24'hDEAD01, 3, 1'b0, acks);
    chk(acks == 6'b0, "R4 other address nacked", {26'b0, acks}, 32'h0);
    do_write(7'h00, 8'h05, 24'hDEAD02, 3, 1'b0, acks);
    chk(acks == 6'b0, "R4 general call nacked", {26'b0, acks}, 32'h0);
    chk(wr_seen == seen0, "R4 no write on mismatch", wr_seen, seen0);

    do_write(7'h08, 8'h09, 24'hBEEF99, 2, 1'b0, acks);
    chk(acks == 6'b001111, "R6 partial write acks", {26'b0, acks}, 32'hF);
    chk(wr_seen == seen0, "R6 partial write no strobe", wr_seen, seen0);
    do_read(7'h08, 8'h09, rd, racks);
    chk(rd == (24'h5A5A5A ^ (24'h010101 * 9)), "R6 register 9 unchanged", {8'b0, rd},
        {8'b0, 24'h5A5A5A ^ (24'h010101 * 9)});

    expq.push_back('{a: 6'd3, d: 24'h314159});
    do_write(7'h08, 8'h03, 24'h314159, 4, 1'b0, acks);
    chk(acks == 6'b011111, "R7 fourth data byte nacked", {26'b0, acks}, 32'h1F);
    chk(wr_seen == seen0 + 1, "R7 single write", wr_seen, seen0 + 1);

    do_read(7'h08, 8'h05, rd, racks);
    chk(racks == 3'b111, "R8 read phase acks", {29'b0, racks}, 32'h7);
    chk(rd == 24'hA1B2C3, "R8 read data", {8'b0, rd}, 32'hA1B2C3);
    chk(sda_pull == 1'b0, "R9 released after read", {31'b0, sda_pull}, 32'h0);
    do_read(7'h08, 8'h07, rd, racks);
    chk(rd == 24'h00FF10, "R8 read second register", {8'b0, rd}, 32'h00FF10);

    expq.push_back('{a: 6'd12, d: 24'h0F1E2D});
    do_write(7'h08, 8'h0C, 24'h0F1E2D, 3, 1'b1, acks);
    chk(acks == 6'b011111, "R10 glitched write acks", {26'b0, acks}, 32'h1F);
    do_read(7'h08, 8'h0C, rd, racks);
    chk(rd == 24'h0F1E2D, "R10 glitched write readback", {8'b0, rd}, 32'h0F1E2D);

    // Mode on, address strap high
    do_reset(1'b1, 1'b1);
    do_write(7'h08, 8'h01, 24'h777777, 3, 1'b0, acks);
    chk(acks == 6'b0, "R3 low address nacked when strap high", {26'b0, acks}, 32'h0);
    expq.push_back('{a: 6'd1, d: 24'h2468AC});
    do_write(7'h0A, 8'h01, 24'h2468AC, 3, 1'b0, acks);
    chk(acks == 6'b011111, "R3 high address acked", {26'b0, acks}, 32'h1F);

    repeat (20) @(negedge clk);
    chk(expq.size() == 0, "R5 all expected writes seen", expq.size(), 32'h0);
    summary();
    $finish;
  end

endmodule